// File: doc/BRIEF.md
# Polled Byte Output Port Controller

This block is a small peripheral that a host processor drives entirely by polling over a simple register bus. The host loads a byte into a data register, then arms a transfer by setting two control bits in the status register. The controller marks itself busy, latches the byte onto a byte-wide device port and offers it with a valid/ready handshake. Once the device takes the byte, the controller drops every handshake bit it owns in a single edge, so the host sees it idle again and may queue the next byte.

A fault input from the device ends a transfer early and leaves a sticky error flag. The flag stays readable until the host reads the status register or arms a new command. Each command moves exactly one byte. The bus read path can be combinational or registered, chosen by a parameter.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset the status register reads 0, the data register reads 0 and dev_valid is low.
- R2: Address 0 reads the status register with busy at bit 0, write at bit 1, command-ready at bit 2 and error at bit 3, and zeros above. Address 1 reads back the data register. Any other address reads 0, and writes to it change nothing.
- R3: A status write only arms a transfer when bits 1 and 2 of the written value are both 1 and neither command-ready nor busy is set. It then sets write and command-ready and clears error. Any other status write is ignored.
- R4: On the clock edge after command-ready is seen with busy clear, busy is set, dev_valid rises and dev_data equals the data register.
- R5: While dev_valid is high and neither dev_ready nor dev_fault is high, dev_valid and dev_data hold their values.
- R6: The edge at which dev_valid and dev_ready are both high without a fault clears busy, write, command-ready and error together and drops dev_valid. dev_valid then stays low until the next command, so one byte moves per command.
- R7: dev_fault high while busy sets error, clears busy, write and command-ready, and drops dev_valid at that edge. A fault wins over a simultaneous dev_ready. A fault while idle has no effect.
- R8: A set error bit stays set until the edge of a status read (bus_rd with address 0) or of an accepted command.
- R9: A host write to the data register while command-ready or busy is set is ignored, and the byte on dev_data does not change.
- R10: With the default read mode, bus_rdata shows the addressed register in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a status read clears error) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| dev_data | output | DATA_W | Byte offered to the device |
| dev_valid | output | 1 | Byte on dev_data is valid |
| dev_ready | input | 1 | Device accepts the byte |
| dev_fault | input | 1 | Device reports a fault |

## Verification
A wrong internal state shows up at the ports within one or two cycles. A stuck busy or command-ready bit reads back in the status word on the next poll. A bad latch shows up as dev_data differing from the byte just loaded on the edge after launch. A missing clear shows up as a nonzero status or a second dev_valid pulse on the edge after the handshake. Because every byte value passes through the port with a range of ready delays, a dropped or swapped data bit appears as a mismatch on the very transfer that carries it.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int ST_BUSY = 0;
   localparam int ST_WRITE = 1;
   localparam int ST_CMD = 2;
   localparam int ST_ERR = 3;
   localparam int ST_W = 4;

   typedef struct packed {
      logic err;
      logic cmd;
      logic wr;
      logic busy;
   } pio_stat_t;
endpackage

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int STAT_ADDR = 0,
   parameter int DOUT_ADDR = 1,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              locked,
   input  pio_stat_t         stat,
   output logic [DATA_W-1:0] dout,
   output logic              stat_wr,
   output logic              stat_rd,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int PAD_W = DATA_W - ST_W;

   logic hit_stat, hit_dout;
   logic [DATA_W-1:0] rd_mux;

   assign hit_stat = (bus_addr == ADDR_W'(STAT_ADDR));
   assign hit_dout = (bus_addr == ADDR_W'(DOUT_ADDR));
   assign stat_wr  = bus_wr & hit_stat;
   assign stat_rd  = bus_rd & hit_stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else if (bus_wr && hit_dout && !locked) dout <= bus_wdata;
   end

   always_comb begin
      rd_mux = '0;
      if (hit_stat) rd_mux = {{PAD_W{1'b0}}, stat};
      else if (hit_dout) rd_mux = dout;
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else if (bus_rd) rd_q <= rd_mux;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/pio_seq.sv
module pio_seq
   import pio_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stat_wr,
   input  logic [ST_W-1:0] stat_wbits,
   input  logic            stat_rd,
   input  logic            xfer_done,
   input  logic            xfer_fault,
   output pio_stat_t       stat,
   output logic            launch
);
   logic arm_ok;

   assign launch = stat.cmd & ~stat.busy;
   assign arm_ok = stat_wr & ~stat.cmd & ~stat.busy
                   & stat_wbits[ST_CMD] & stat_wbits[ST_WRITE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
      end else if (stat.busy && xfer_fault) begin
         stat <= '{err: 1'b1, cmd: 1'b0, wr: 1'b0, busy: 1'b0};
      end else if (stat.busy && xfer_done) begin
         stat <= '0;
      end else if (launch) begin
         stat.busy <= 1'b1;
      end else if (arm_ok) begin
         stat <= '{err: 1'b0, cmd: 1'b1, wr: 1'b1, busy: 1'b0};
      end else if (stat_rd) begin
         stat.err <= 1'b0;
      end
   end
endmodule

// File: rtl/pio_tx.sv
module pio_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              dev_ready,
   input  logic              dev_fault,
   output logic [DATA_W-1:0] dev_data,
   output logic              dev_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_valid <= 1'b0;
         dev_data  <= '0;
      end else if (dev_valid) begin
         if (dev_fault || dev_ready) dev_valid <= 1'b0;
      end else if (launch) begin
         dev_valid <= 1'b1;
         dev_data  <= byte_in;
      end
   end
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
   import pio_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int STAT_ADDR = 0,
   parameter int DOUT_ADDR = 1,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] dev_data,
   output logic              dev_valid,
   input  logic              dev_ready,
   input  logic              dev_fault
);
   generate
      if (DATA_W < ST_W) begin : g_bad_width
         $error("DATA_W must hold the status bits");
      end
      if (STAT_ADDR == DOUT_ADDR) begin : g_bad_map
         $error("status and data addresses must differ");
      end
      if (DOUT_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register address outside ADDR_W range");
      end
   endgenerate

   pio_stat_t         stat_q;
   logic              launch, stat_wr, stat_rd;
   logic [DATA_W-1:0] dout_q;

   pio_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
      .DOUT_ADDR(DOUT_ADDR), .RDATA_REG(RDATA_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .locked(stat_q.cmd | stat_q.busy), .stat(stat_q),
      .dout(dout_q), .stat_wr(stat_wr), .stat_rd(stat_rd),
      .bus_rdata(bus_rdata)
   );

   pio_seq u_seq (
      .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr),
      .stat_wbits(bus_wdata[ST_W-1:0]), .stat_rd(stat_rd),
      .xfer_done(dev_valid & dev_ready), .xfer_fault(dev_fault),
      .stat(stat_q), .launch(launch)
   );

   pio_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .launch(launch), .byte_in(dout_q),
      .dev_ready(dev_ready), .dev_fault(dev_fault),
      .dev_data(dev_data), .dev_valid(dev_valid)
   );
endmodule

// File: rtl/pio_port_ctrl_chk.sv
module pio_port_ctrl_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int STAT_ADDR = 0,
   parameter int DOUT_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] dev_data,
   input logic              dev_valid,
   input logic              dev_ready,
   input logic              dev_fault,
   input logic [3:0]        stat,
   input logic [DATA_W-1:0] dout
);
   AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      dev_valid |-> stat[0]); // R4
   AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[2] && !stat[0]) |=> (stat[0] && dev_valid && dev_data == $past(dout))); // R4
   AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid && !dev_ready && !dev_fault) |=> (dev_valid && $stable(dev_data))); // R5
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid && dev_ready && !dev_fault) |=> (stat == 4'b0000 && !dev_valid)); // R6
   AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[0] && dev_fault) |=> (stat == 4'b1000 && !dev_valid)); // R7
   AST_READ_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == ADDR_W'(STAT_ADDR) && !stat[0]) |=> !stat[3]); // R8
   AST_DOUT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat[0] || stat[2]) && bus_wr && bus_addr == ADDR_W'(DOUT_ADDR)) |=> $stable(dout)); // R9
endmodule

bind pio_port_ctrl pio_port_ctrl_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DOUT_ADDR(DOUT_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .dev_data(dev_data), .dev_valid(dev_valid),
   .dev_ready(dev_ready), .dev_fault(dev_fault), .stat(stat_q), .dout(dout_q)
);

// File: tb/tb_pio_port_ctrl.sv
module tb_pio_port_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata, dev_data;
   logic          dev_valid;
   logic          dev_ready = 1'b0, dev_fault = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dev_data(dev_data), .dev_valid(dev_valid),
      .dev_ready(dev_ready), .dev_fault(dev_fault)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // combinational peek at a register (no clock edge, no side effect)
   task automatic peek(input int a, output int v);
      bus_addr = AW'(a);
      bus_rd = 1'b0;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = DW'(d); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_stat();
      @(negedge clk);
      bus_addr = '0; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      peek(0, v); chk("R1 status", v, 0);
      peek(1, v); chk("R1 dout", v, 0);
      chk("R1 valid", dev_valid, 0);

      // R2: unmapped address
      wr(2, 8'h5A);
      peek(2, v); chk("R2 unmapped read", v, 0);
      peek(0, v); chk("R2 status untouched", v, 0);
      peek(1, v); chk("R2 dout untouched", v, 0);

      // R3: partial command words ignored
      wr(0, 8'h04); peek(0, v); chk("R3 cmd only", v, 0);
      wr(0, 8'h02); peek(0, v); chk("R3 write only", v, 0);
      wr(0, 8'h01); peek(0, v); chk("R3 busy bit write", v, 0);
      // R7: fault while idle
      @(negedge clk); dev_fault = 1'b1; @(negedge clk); dev_fault = 1'b0;
      peek(0, v); chk("R7 idle fault", v, 0);

      // sweep all byte values with ready delays 0..3
      for (int b = 0; b < 256; b++) begin
         int dly;
         dly = b % 4;
         wr(1, b);
         peek(1, v); chk("R2 dout readback", v, b);
         wr(0, 8'h06);
         peek(0, v); chk("R3 armed", v, 8'h06);        // R10 same-cycle read
         chk("R4 not yet valid", dev_valid, 0);
         @(negedge clk);
         peek(0, v); chk("R4 busy", v, 8'h07);
         chk("R4 valid", dev_valid, 1);
         chk("R4 data", dev_data, b);
         for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk("R5 hold valid", dev_valid, 1);
            chk("R5 hold data", dev_data, b);
         end
         if (b % 16 == 5) begin
            wr(1, b ^ 8'hFF);
            peek(1, v); chk("R9 dout locked", v, b);
            chk("R9 data stable", dev_data, b);
            wr(0, 8'h06);
            peek(0, v); chk("R3 busy rejects arm", v, 8'h07);
         end
         @(negedge clk); dev_ready = 1'b1;
         @(negedge clk); dev_ready = 1'b0;
         peek(0, v); chk("R6 status cleared", v, 0);
         chk("R6 valid dropped", dev_valid, 0);
         @(negedge clk);
         chk("R6 single byte", dev_valid, 0);
      end

      // R7: fault during transfer, then R8 clear by status read
      wr(1, 8'hC3); wr(0, 8'h06); @(negedge clk);
      dev_fault = 1'b1; @(negedge clk); dev_fault = 1'b0;
      peek(0, v); chk("R7 fault status", v, 8'h08);
      chk("R7 valid dropped", dev_valid, 0);
      repeat (3) @(negedge clk);
      peek(0, v); chk("R8 error sticky", v, 8'h08);
      rd_stat();
      peek(0, v); chk("R8 read clears", v, 0);

      // R7: fault and ready together, then R8 clear by new command
      wr(1, 8'h3C); wr(0, 8'h06); @(negedge clk);
      dev_fault = 1'b1; dev_ready = 1'b1;
      @(negedge clk); dev_fault = 1'b0; dev_ready = 1'b0;
      peek(0, v); chk("R7 fault wins", v, 8'h08);
      wr(0, 8'h06);
      peek(0, v); chk("R8 command clears", v, 8'h06);
      @(negedge clk);
      chk("R4 data after fault", dev_data, 8'h3C);
      dev_ready = 1'b1; @(negedge clk); dev_ready = 1'b0;
      peek(0, v); chk("R6 final clear", v, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule